// File: doc/BRIEF.md
# Arbitration Lost Position Capture

This block records where in a CAN frame header the node lost arbitration. The bit stream logic supplies a one-cycle loss strobe and the 5-bit index of the header bit being sent. The first loss after arming stores that index in a CPU-visible register and locks it. Later losses leave the register unchanged until software reads it once. The read leaves the stored value in place and arms the register again.

While the register is locked, the block also blocks the arbitration-lost interrupt request. A request pulse is issued only for a loss that is actually captured, and only when the interrupt enable is set. The block also decodes the stored index into a header field class and the identifier bit number it names. Software or a neighbouring block can then use the position without a lookup table.

Top module: `arbloss_capture`

## Requirements
- R1: After reset, `cap_value` is zero, `cap_locked` is 0 and `irq_req` is 0. The register is armed.
- R2: A `loss_stb` in a clock cycle where the register is unlocked and `cap_read` is low stores `bit_pos`. The value appears on `cap_value[4:0]`, and `cap_locked` reads 1, from the next cycle.
- R3: While `cap_locked` is 1, further `loss_stb` pulses do not change `cap_value`.
- R4: A `cap_read` pulse makes `cap_locked` read 0 from the next cycle. `cap_value` keeps the value it held.
- R5: A `loss_stb` in the same cycle as `cap_read` is ignored. Nothing is captured and no request is raised. The register is armed in the following cycle.
- R6: `irq_req` is high for exactly the one cycle after a captured loss, and only if `irq_enable` was 1 in the loss cycle. With the enable at 0, the capture still takes place but no pulse is issued.
- R7: A loss that arrives while the register is locked raises no `irq_req`.
- R8: `cap_value` bits 7 to 5 always read 0.
- R9: A stored code 0 to 10 decodes to field class 0 (base identifier). `pos_id_bit` then equals 28 minus the code.
- R10: Code 11 decodes to class 1 (substitute or standard remote-request bit) and code 12 to class 2 (identifier-extension bit). In both cases `pos_id_bit` is 0.
- R11: A code 13 to 30 decodes to class 3 (extended identifier), with `pos_id_bit` equal to 30 minus the code. Code 31 decodes to class 4 (extended remote-request bit) with `pos_id_bit` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loss_stb | input | 1 | One-cycle strobe: arbitration lost at the current bit |
| bit_pos | input | 5 | Current header bit index from the bit stream logic |
| irq_enable | input | 1 | Arbitration-lost interrupt enable |
| cap_read | input | 1 | CPU read strobe of the capture register |
| cap_value | output | 8 | Capture register as read by the CPU |
| irq_req | output | 1 | Gated arbitration-lost interrupt request pulse |
| cap_locked | output | 1 | High while an unread capture is held |
| pos_kind | output | 3 | Header field class of the stored position |
| pos_id_bit | output | 5 | Identifier bit number of the stored position |

## Verification
The main function is driven with four kinds of input pattern, and a behavioural model is compared every cycle.

- **Lone losses with and without the enable.** These separate the capture path from the interrupt gate.
- **Bursts of losses against a locked register.** These show whether the lock holds both the value and the request.
- **Reads alone and reads that coincide with a loss.** These distinguish rearming from capturing, and show the priority of the read.
- **A sweep of every code from 0 to 31, each followed by a read.** This exercises every boundary of the field decode: 10/11, 12/13 and 30/31.

// File: rtl/arbloss_pkg.sv
package arbloss_pkg;

   // Header field classes of a stored arbitration position
   typedef enum logic [2:0] {
      FK_BASE_ID = 3'd0,
      FK_SUB_RTR = 3'd1,
      FK_ID_EXT  = 3'd2,
      FK_EXT_ID  = 3'd3,
      FK_EXT_RTR = 3'd4
   } fld_kind_e;

   // Header layout in arbitration order
   localparam int BASE_ID_BITS = 11;
   localparam int EXT_ID_BITS  = 18;
   localparam int ALL_ID_BITS  = BASE_ID_BITS + EXT_ID_BITS;
   localparam int SUBRTR_CODE  = BASE_ID_BITS;
   localparam int IDEXT_CODE   = BASE_ID_BITS + 1;
   localparam int EXT_FIRST    = BASE_ID_BITS + 2;
   localparam int EXT_LAST     = EXT_FIRST + EXT_ID_BITS - 1;
   localparam int RTR_CODE     = EXT_LAST + 1;

endpackage

// File: rtl/arbloss_lock.sv
module arbloss_lock #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loss_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             en_i,
   input  logic             rd_i,
   output logic [IDX_W-1:0] pos_o,
   output logic             locked_o,
   output logic             irq_o
);

   logic [IDX_W-1:0] pos_q;
   logic             locked_q;
   logic             irq_q;
   logic             take;

   // A loss is accepted only into an armed register and never beside a read
   assign take = loss_i & ~locked_q & ~rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         locked_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= take & en_i;
         if (rd_i) begin
            locked_q <= 1'b0;
         end else if (take) begin
            pos_q    <= idx_i;
            locked_q <= 1'b1;
         end
      end
   end

   assign pos_o    = pos_q;
   assign locked_o = locked_q;
   assign irq_o    = irq_q;

   p_capture_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (loss_i && !locked_o && !rd_i) |=> (locked_o && pos_o == $past(idx_i)));

   p_hold_locked_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && !rd_i) |=> $stable(pos_o));

   p_rearm_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (!locked_o && $stable(pos_o)));

   p_read_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (loss_i && rd_i) |=> !irq_o);

   p_no_irq_disabled_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (loss_i && !en_i) |=> !irq_o);

   p_irq_single_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_no_irq_locked_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> !irq_o);

endmodule

// File: rtl/arbloss_decode.sv
module arbloss_decode
   import arbloss_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int ID_W  = 5
) (
   input  logic [IDX_W-1:0] code_i,
   output fld_kind_e        kind_o,
   output logic [ID_W-1:0]  id_bit_o
);

   int c;

   always_comb begin
      c        = int'(code_i);
      kind_o   = FK_EXT_RTR;
      id_bit_o = '0;
      if (c < SUBRTR_CODE) begin
         kind_o   = FK_BASE_ID;
         id_bit_o = ID_W'(ALL_ID_BITS - 1 - c);
      end else if (c == SUBRTR_CODE) begin
         kind_o = FK_SUB_RTR;
      end else if (c == IDEXT_CODE) begin
         kind_o = FK_ID_EXT;
      end else if (c <= EXT_LAST) begin
         kind_o   = FK_EXT_ID;
         id_bit_o = ID_W'(EXT_LAST - c);
      end
   end

   // R11: an extended identifier position never names a base identifier bit
   always_comb begin
      if (kind_o == FK_EXT_ID)
         p_ext_range_r11 : assert (int'(id_bit_o) < EXT_ID_BITS);
   end

endmodule

// File: rtl/arbloss_capture.sv
module arbloss_capture
   import arbloss_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int REG_W = 8,
   parameter int ID_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loss_stb,
   input  logic [IDX_W-1:0] bit_pos,
   input  logic             irq_enable,
   input  logic             cap_read,
   output logic [REG_W-1:0] cap_value,
   output logic             irq_req,
   output logic             cap_locked,
   output logic [2:0]       pos_kind,
   output logic [ID_W-1:0]  pos_id_bit
);

   localparam int PAD_W = REG_W - IDX_W;

   generate
      if (REG_W < IDX_W) begin : g_bad_reg_w
         $error("REG_W must hold the position index");
      end
      if ((1 << IDX_W) <= RTR_CODE) begin : g_bad_idx_w
         $error("IDX_W too narrow for the header positions");
      end
      if ((1 << ID_W) < ALL_ID_BITS) begin : g_bad_id_w
         $error("ID_W too narrow for the identifier bit number");
      end
   endgenerate

   logic [IDX_W-1:0] pos;
   fld_kind_e        kind;

   arbloss_lock #(.IDX_W(IDX_W)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .loss_i   (loss_stb),
      .idx_i    (bit_pos),
      .en_i     (irq_enable),
      .rd_i     (cap_read),
      .pos_o    (pos),
      .locked_o (cap_locked),
      .irq_o    (irq_req)
   );

   arbloss_decode #(.IDX_W(IDX_W), .ID_W(ID_W)) u_dec (
      .code_i   (pos),
      .kind_o   (kind),
      .id_bit_o (pos_id_bit)
   );

   assign pos_kind = kind;

   generate
      if (PAD_W > 0) begin : g_pad
         assign cap_value = {{PAD_W{1'b0}}, pos};
         // R8: reserved bits stay zero
         always_comb begin
            p_upper_zero_r8 : assert (cap_value[REG_W-1:IDX_W] == '0);
         end
      end else begin : g_nopad
         assign cap_value = pos;
      end
   endgenerate

endmodule

// File: tb/sim_arbloss_capture.sv
module sim_arbloss_capture;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loss_stb = 1'b0;
   logic [4:0] bit_pos = '0;
   logic       irq_enable = 1'b0;
   logic       cap_read = 1'b0;
   logic [7:0] cap_value;
   logic       irq_req;
   logic       cap_locked;
   logic [2:0] pos_kind;
   logic [4:0] pos_id_bit;

   int n_vec = 0;
   int n_bad = 0;

   // Reference model state
   int m_pos  = 0;
   bit m_lock = 0;
   bit m_irq  = 0;

   always #(PERIOD/2) clk = ~clk;

   arbloss_capture u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .loss_stb   (loss_stb),
      .bit_pos    (bit_pos),
      .irq_enable (irq_enable),
      .cap_read   (cap_read),
      .cap_value  (cap_value),
      .irq_req    (irq_req),
      .cap_locked (cap_locked),
      .pos_kind   (pos_kind),
      .pos_id_bit (pos_id_bit)
   );

   function automatic int ref_kind(int c);
      if (c <= 10) return 0;
      if (c == 11) return 1;
      if (c == 12) return 2;
      if (c <= 30) return 3;
      return 4;
   endfunction

   function automatic int ref_id(int c);
      if (c <= 10) return 28 - c;
      if (c >= 13 && c <= 30) return 30 - c;
      return 0;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "cap_value[4:0]", int'(cap_value[4:0]), m_pos);
      chk(tag, "cap_value[7:5] R8", int'(cap_value[7:5]), 0);
      chk(tag, "cap_locked", int'(cap_locked), int'(m_lock));
      chk(tag, "irq_req", int'(irq_req), int'(m_irq));
      chk(tag, "pos_kind", int'(pos_kind), ref_kind(m_pos));
      chk(tag, "pos_id_bit", int'(pos_id_bit), ref_id(m_pos));
   endtask

   // Drive one cycle (called just after a falling edge), update model, compare
   task automatic step(string tag, bit loss, int idx, bit en, bit rd);
      bit take;
      loss_stb   = loss;
      bit_pos    = 5'(idx);
      irq_enable = en;
      cap_read   = rd;
      @(posedge clk);
      take  = loss && !m_lock && !rd;
      m_irq = take && en;
      if (rd) m_lock = 0;
      else if (take) begin
         m_pos  = idx;
         m_lock = 1;
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // capture with interrupt
      step("R2", 1, 5, 1, 0);
      step("R6", 0, 0, 1, 0);
      // losses while locked
      step("R3", 1, 9, 1, 0);
      step("R7", 1, 22, 1, 0);
      step("R3", 0, 0, 1, 0);
      // read rearms, value kept
      step("R4", 0, 0, 1, 1);
      step("R4", 0, 0, 1, 0);
      // capture with enable off
      step("R6", 1, 20, 0, 0);
      step("R6", 0, 0, 0, 0);
      step("R4", 0, 0, 0, 1);
      // loss coinciding with read while armed
      step("R5", 1, 3, 1, 1);
      step("R5", 0, 0, 1, 0);
      step("R5", 1, 7, 1, 0);
      // loss coinciding with read while locked
      step("R5", 1, 14, 1, 1);
      step("R5", 1, 15, 1, 0);
      step("R5", 0, 0, 1, 1);
      // back-to-back losses from armed
      step("R2", 1, 31, 1, 0);
      step("R8", 1, 30, 1, 0);
      step("R8", 0, 0, 1, 1);

      // sweep every position code
      for (int c = 0; c < 32; c++) begin
         string t;
         if (c <= 10) t = "R9";
         else if (c <= 12) t = "R10";
         else t = "R11";
         step(t, 1, c, c[0], 0);
         step(t, 0, 0, 0, 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule